// File: doc/BRIEF.md
# Sync Header Block Alignment Lock

This block sits after a receive gearbox in a 64b/66b receiver. It decides whether the gearbox has found the right 66-bit block boundary. The gearbox presents the two framing bits of each candidate block together with a one-cycle strobe. Each header is graded as good or bad, and the block counts over fixed windows of blocks.

While hunting, every header in one full window must be good before lock is declared. A single bad header during the hunt rejects the current bit offset at once. When lock is held, it is dropped only when a window collects a limit of bad headers. Each rejection produces a one-cycle slip pulse that asks the gearbox to move by one bit. The block that arrives right after a slip still belongs to the old alignment, so it is discarded. When the line reports no signal, the block returns to hunting and lock is held low.

Top module: `blk_lock_fsm`

## Requirements
- R1: A header `hdr[1:0]` of 2'b01 or 2'b10 counts as good, and 2'b00 or 2'b11 counts as bad.
- R2: While `sig_ok` is low, `block_lock` and `slip` are low from the next cycle on. Counting restarts from an empty window in the hunting state once `sig_ok` returns. Both outputs are low after reset.
- R3: While hunting, `block_lock` rises in the cycle after the 64th consecutive counted good header.
- R4: While hunting, a counted bad header makes `slip` high in the next cycle, and all counts restart.
- R5: While locked, the 16th bad header counted inside one 64-block window drops `block_lock` and raises `slip` in the same next cycle.
- R6: While locked, a 64-block window that ends with fewer than 16 bad headers keeps lock and clears both counts. Bad headers therefore never add up across windows.
- R7: `slip` is never high for two cycles in a row.
- R8: After a slip, the first strobed block is discarded whatever its header. Counting resumes with the block after it.
- R9: Cycles without `blk_vld` change neither the counts nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_ok | input | 1 | Line signal present |
| blk_vld | input | 1 | One-cycle strobe: a new block header is on `hdr` |
| hdr | input | 2 | Framing bits of the current block |
| block_lock | output | 1 | Block alignment achieved (registered) |
| slip | output | 1 | One-cycle request to shift the gearbox by one bit |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that `hdr` matters only in a cycle where `blk_vld` is high. The `$past` terms read the header and strobe from the cycle before the output changes, so the inputs must be stable around the sampling edge. The stimulus changes every input only at the falling edge. It leaves `hdr` at arbitrary values during idle cycles, which exercises the rule that the header is ignored when no strobe is present.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_LOCKED = 2'd1,
        ST_SKIP   = 2'd2
    } lock_st_e;

    typedef struct packed {
        lock_st_e st;
        logic     slip;
    } lock_reg_t;

endpackage

// File: rtl/hdr_classify.sv
module hdr_classify #(
    parameter int HDR_W = 2
) (
    input  logic [HDR_W-1:0] hdr,
    output logic             hdr_ok
);
    // A framing header is good only when its bits differ.
    always_comb begin
        hdr_ok = 1'b0;
        for (int i = 1; i < HDR_W; i++) begin
            if (hdr[i] != hdr[0]) hdr_ok = 1'b1;
        end
    end
endmodule

// File: rtl/win_counter.sv
module win_counter #(
    parameter int WIN_BLKS = 64,
    parameter int BAD_LIM  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    input  logic bad,
    output logic win_last,
    output logic bad_last
);
    localparam int BLK_W = (WIN_BLKS > 1) ? $clog2(WIN_BLKS) : 1;
    localparam int BAD_W = (BAD_LIM > 1) ? $clog2(BAD_LIM) : 1;
    localparam logic [BLK_W-1:0] BLK_END = BLK_W'(WIN_BLKS - 1);
    localparam logic [BAD_W-1:0] BAD_END = BAD_W'(BAD_LIM - 1);

    logic [BLK_W-1:0] blk_cnt_d, blk_cnt_q;
    logic [BAD_W-1:0] bad_cnt_d, bad_cnt_q;

    always_comb begin
        blk_cnt_d = blk_cnt_q;
        bad_cnt_d = bad_cnt_q;
        if (clr) begin
            blk_cnt_d = '0;
            bad_cnt_d = '0;
        end else if (inc) begin
            blk_cnt_d = blk_cnt_q + 1'b1;
            if (bad) bad_cnt_d = bad_cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_cnt_q <= '0;
            bad_cnt_q <= '0;
        end else begin
            blk_cnt_q <= blk_cnt_d;
            bad_cnt_q <= bad_cnt_d;
        end
    end

    assign win_last = (blk_cnt_q == BLK_END);
    assign bad_last = (bad_cnt_q == BAD_END);
endmodule

// File: rtl/blk_lock_fsm.sv
module blk_lock_fsm
    import blk_lock_pkg::*;
#(
    parameter int WIN_BLKS = 64,
    parameter int BAD_LIM  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_ok,
    input  logic       blk_vld,
    input  logic [1:0] hdr,
    output logic       block_lock,
    output logic       slip
);
    lock_reg_t r_d, r_q;
    logic hdr_ok, win_last, bad_last, cnt_clr, cnt_inc;

    hdr_classify #(.HDR_W(2)) cls_i (
        .hdr    (hdr),
        .hdr_ok (hdr_ok)
    );

    win_counter #(.WIN_BLKS(WIN_BLKS), .BAD_LIM(BAD_LIM)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .bad      (!hdr_ok),
        .win_last (win_last),
        .bad_last (bad_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.slip = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        if (!sig_ok) begin
            r_d.st  = ST_HUNT;
            cnt_clr = 1'b1;
        end else if (blk_vld) begin
            unique case (r_q.st)
                ST_SKIP: begin
                    // block still framed at the old offset: drop it
                    r_d.st = ST_HUNT;
                end
                ST_HUNT: begin
                    cnt_inc = 1'b1;
                    if (!hdr_ok) begin
                        r_d.st   = ST_SKIP;
                        r_d.slip = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (win_last) begin
                        r_d.st  = ST_LOCKED;
                        cnt_clr = 1'b1;
                    end
                end
                ST_LOCKED: begin
                    cnt_inc = 1'b1;
                    if (!hdr_ok && bad_last) begin
                        r_d.st   = ST_SKIP;
                        r_d.slip = 1'b1;
                        cnt_clr  = 1'b1;
                    end else if (win_last) begin
                        cnt_clr = 1'b1;
                    end
                end
                default: begin
                    r_d.st  = ST_HUNT;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_HUNT, slip: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign block_lock = (r_q.st == ST_LOCKED);
    assign slip       = r_q.slip;

    AST_NO_LOCK_WO_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ok |=> (!block_lock && !slip)); // R2
    AST_LOCK_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(block_lock) |-> $past(sig_ok && blk_vld && hdr_ok)); // R3
    AST_SLIP_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        slip |-> $past(blk_vld && !hdr_ok)); // R4
    AST_UNLOCK_SLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(block_lock) && $past(sig_ok)) |-> slip); // R5
    AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        slip |=> !slip); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_ok && !blk_vld) |=> ($stable(block_lock) && !slip)); // R9
endmodule

// File: tb/blk_lock_fsm_tb_top.sv
module blk_lock_fsm_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sig_ok = 1'b0;
    logic blk_vld = 1'b0;
    logic [1:0] hdr = 2'b00;
    logic block_lock, slip;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R2";

    // reference model state
    int  m_nb = 0, m_nbad = 0;
    bit  m_lock = 0, m_slip = 0, m_skip = 0;

    always #2 clk = ~clk;

    blk_lock_fsm dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_ok     (sig_ok),
        .blk_vld    (blk_vld),
        .hdr        (hdr),
        .block_lock (block_lock),
        .slip       (slip)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_nb = 0; m_nbad = 0; m_lock = 0; m_slip = 0; m_skip = 0;
        end else begin
            m_slip = 0;
            if (!sig_ok) begin
                m_lock = 0; m_skip = 0; m_nb = 0; m_nbad = 0;
            end else if (blk_vld) begin
                if (m_skip) begin
                    m_skip = 0;
                end else begin
                    bit bad;
                    bad = (hdr == 2'b00) || (hdr == 2'b11);
                    m_nb++;
                    if (bad) m_nbad++;
                    if (!m_lock) begin
                        if (bad) begin
                            m_slip = 1; m_skip = 1; m_nb = 0; m_nbad = 0;
                        end else if (m_nb == 64) begin
                            m_lock = 1; m_nb = 0; m_nbad = 0;
                        end
                    end else begin
                        if (m_nbad == 16) begin
                            m_lock = 0; m_slip = 1; m_skip = 1; m_nb = 0; m_nbad = 0;
                        end else if (m_nb == 64) begin
                            m_nb = 0; m_nbad = 0;
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (block_lock !== m_lock || slip !== m_slip) begin
                n_fail++;
                $display("FAIL %s cycle %0d: lock/slip actual %b%b expected %b%b",
                         cur_req, cyc, block_lock, slip, m_lock, m_slip);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected finish before 50000", cyc);
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic step(input bit v, input logic [1:0] h);
        @(negedge clk);
        blk_vld = v;
        hdr = h;
    endtask

    task automatic expect_out(input bit el, input bit es, input string req);
        n_chk++;
        if (block_lock !== el || slip !== es) begin
            n_fail++;
            $display("FAIL %s: lock/slip actual %b%b expected %b%b", req, block_lock, slip, el, es);
        end
    endtask

    initial begin
        repeat (4) step(0, 2'b00);
        rst_n = 1'b1;
        step(0, 2'b11);
        expect_out(0, 0, "R2 reset");

        // no signal: good headers do not lock
        cur_req = "R2";
        for (int i = 0; i < 70; i++) step(1, 2'b01);
        step(0, 2'b00);
        expect_out(0, 0, "R2 no signal");

        // hunt: 64 good headers with idle gaps carrying junk headers
        cur_req = "R3";
        sig_ok = 1'b1;
        step(0, 2'b00);
        for (int i = 0; i < 63; i++) begin
            step(1, (i % 2) ? 2'b10 : 2'b01);
            if (i % 7 == 3) step(0, 2'b11);
        end
        step(0, 2'b00);
        expect_out(0, 0, "R3 63 good");
        expect_out(0, 0, "R9 idle junk ignored");
        step(1, 2'b01);
        step(0, 2'b00);
        expect_out(1, 0, "R3 64th good");

        // locked: two windows of 15 bad each keep lock
        cur_req = "R6";
        for (int w = 0; w < 2; w++) begin
            for (int i = 0; i < 64; i++)
                step(1, (i % 4 == 0 && i < 60) ? 2'b00 : 2'b10);
            step(0, 2'b00);
            expect_out(1, 0, "R6 15 bad per window");
        end

        // locked: 16 bad in one window drops lock
        cur_req = "R5";
        for (int i = 0; i < 15; i++) step(1, 2'b11);
        step(0, 2'b00);
        expect_out(1, 0, "R5 15 bad");
        step(1, 2'b11);
        step(0, 2'b00);
        expect_out(0, 1, "R5 16th bad");
        step(0, 2'b00);
        expect_out(0, 0, "R7 slip one cycle");

        // after slip the first block is dropped
        cur_req = "R8";
        step(1, 2'b00);
        step(0, 2'b01);
        expect_out(0, 0, "R8 dropped block");
        cur_req = "R4";
        step(1, 2'b11);
        step(0, 2'b00);
        expect_out(0, 1, "R4 R1 bad while hunting");
        step(0, 2'b00);
        expect_out(0, 0, "R7 pulse end");
        cur_req = "R8";
        step(1, 2'b01);
        for (int i = 0; i < 63; i++) step(1, (i % 2) ? 2'b01 : 2'b10);
        step(0, 2'b00);
        expect_out(0, 0, "R8 dropped block not counted");
        step(1, 2'b10);
        step(0, 2'b00);
        expect_out(1, 0, "R1 R3 mixed good codes lock");

        // idle cycles with bad headers while locked
        cur_req = "R9";
        for (int i = 0; i < 40; i++) step(0, 2'b11);
        expect_out(1, 0, "R9 idle while locked");

        // signal loss while locked
        cur_req = "R2";
        sig_ok = 1'b0;
        step(0, 2'b00);
        sig_ok = 1'b1;
        step(0, 2'b00);
        expect_out(0, 0, "R2 signal loss");
        for (int i = 0; i < 64; i++) step(1, 2'b01);
        step(0, 2'b00);
        expect_out(1, 0, "R2 relock after signal returns");

        repeat (3) step(0, 2'b00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule